// File: doc/BRIEF.md
# Conditional Select Unit

This unit chooses between two operands under control of a flag-based condition, in one registered stage. A 4-bit condition code is tested against the current N, Z, C and V flags. If the test holds, the result is the first operand. If it fails, the result comes from the second operand, after one of four transforms chosen by a 2-bit operation field: passed as is, bitwise inverted, negated in two's complement, or incremented by one.

Each operand has its own zero-force bit that replaces it with zero, which models a hardwired zero register. With these bits and an inverted condition code, the same four operations also give conditional invert, conditional increment, conditional negate, and set-on-condition as either 1 or an all-ones mask. A width control selects 64-bit or 32-bit operation. In 32-bit mode the upper half of the result is cleared. The result is available one cycle after a valid input, and an output valid bit follows the input valid bit.

Top module: `csel_unit`

## Requirements
- R1: When the condition holds, the result is the first operand for every operation (opSel 0 through 3).
- R2: When the condition fails, opSel 0 returns the second operand unchanged.
- R3: When the condition fails, opSel 1 returns the bitwise inverse of the second operand.
- R4: When the condition fails, opSel 2 returns the two's-complement negation of the second operand.
- R5: When the condition fails, opSel 3 returns the second operand plus one, wrapping to zero from all ones.
- R6: The condition codes are evaluated against the flags as follows:
  - Base tests, selected by code bits [3:1]:
    - 0: Z
    - 1: C
    - 2: N
    - 3: V
    - 4: C and not Z
    - 5: N equals V
    - 6: not Z and N equals V
    - 7: always true
  - For codes below 14, code bit 0 set inverts the base test.
  - Codes 14 and 15 are always true.
- R7: zeroA set replaces the first operand with zero, and zeroB set replaces the second operand with zero, before selection.
- R8: When is32 is set, result bits [63:32] are zero and the transforms act on the low 32 bits.
- R9: outValid equals inValid from the previous cycle. The result register loads only on a valid input and otherwise holds its value.
- R10: During reset, outValid is 0 and the result is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rstN | input | 1 | active-low asynchronous reset |
| inValid | input | 1 | input operation valid |
| opSel | input | 2 | false-path transform: 0 pass, 1 invert, 2 negate, 3 increment |
| condCode | input | 4 | condition code |
| flags | input | 4 | flags as {N,Z,C,V} |
| is32 | input | 1 | 32-bit operation |
| zeroA | input | 1 | force first operand to zero |
| zeroB | input | 1 | force second operand to zero |
| opA | input | 64 | first operand |
| opB | input | 64 | second operand |
| outValid | output | 1 | result valid |
| result | output | 64 | registered result |

## Verification
All sixteen condition codes are swept across all sixteen flag combinations. This separates the base tests from one another and shows that code bit 0 inverts each base test while codes 14 and 15 stay true. Operand pairs that differ in every transform's output (zero, all ones, a carry boundary, and mixed patterns) are run through each operation in both widths. This shows whether a wrong transform, a missing upper-half clear, or a carry out of 32 bits can pass unnoticed. The derived forms are checked by tying the operands together or forcing them to zero with the inverted code, and idle cycles with changing inputs show whether the result register holds.

// File: rtl/csel_pkg.sv
package csel_pkg;
  localparam int DataW = 64;
  localparam int HalfW = DataW / 2;

  typedef enum logic [1:0] {
    OP_PASS = 2'd0,
    OP_INV  = 2'd1,
    OP_NEG  = 2'd2,
    OP_INC  = 2'd3
  } opSel_t;

  typedef struct packed {
    logic   takeA;
    logic   is32;
    logic   zeroA;
    logic   zeroB;
    opSel_t op;
    logic   load;
  } cselCtrl_t;
endpackage

// File: rtl/csel_ctrl.sv
module csel_ctrl
  import csel_pkg::*;
(
  input  logic       inValid,
  input  logic [1:0] opSel,
  input  logic [3:0] condCode,
  input  logic [3:0] flags,
  input  logic       is32,
  input  logic       zeroA,
  input  logic       zeroB,
  output cselCtrl_t  ctrl
);
  logic flagN, flagZ, flagC, flagV;
  logic baseTest;
  logic condTrue;

  assign {flagN, flagZ, flagC, flagV} = flags;

  always_comb begin
    unique case (condCode[3:1])
      3'd0: baseTest = flagZ;
      3'd1: baseTest = flagC;
      3'd2: baseTest = flagN;
      3'd3: baseTest = flagV;
      3'd4: baseTest = flagC & ~flagZ;
      3'd5: baseTest = (flagN == flagV);
      3'd6: baseTest = ~flagZ & (flagN == flagV);
      default: baseTest = 1'b1;
    endcase
    if (condCode[3:1] == 3'd7) condTrue = 1'b1;
    else                        condTrue = baseTest ^ condCode[0];
  end

  always_comb begin
    ctrl.takeA = condTrue;
    ctrl.is32  = is32;
    ctrl.zeroA = zeroA;
    ctrl.zeroB = zeroB;
    ctrl.op    = opSel_t'(opSel);
    ctrl.load  = inValid;
  end
endmodule

// File: rtl/csel_datapath.sv
module csel_datapath
  import csel_pkg::*;
#(
  parameter int Width = DataW
) (
  input  logic             clk,
  input  logic             rstN,
  input  cselCtrl_t        ctrl,
  input  logic [Width-1:0] opA,
  input  logic [Width-1:0] opB,
  output logic             outValid,
  output logic [Width-1:0] result
);
  localparam int Half = Width / 2;

  logic [Width-1:0] srcA, srcB, altB, chosen, masked;

  assign srcA = ctrl.zeroA ? '0 : opA;
  assign srcB = ctrl.zeroB ? '0 : opB;

  always_comb begin
    unique case (ctrl.op)
      OP_PASS: altB = srcB;
      OP_INV:  altB = ~srcB;
      OP_NEG:  altB = ~srcB + Width'(1);
      default: altB = srcB + Width'(1);
    endcase
  end

  assign chosen = ctrl.takeA ? srcA : altB;
  assign masked = ctrl.is32 ? {{(Width-Half){1'b0}}, chosen[Half-1:0]} : chosen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid <= 1'b0;
      result   <= '0;
    end else begin
      outValid <= ctrl.load;
      if (ctrl.load) result <= masked;
    end
  end
endmodule

// File: rtl/csel_unit.sv
module csel_unit
  import csel_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic [1:0]       opSel,
  input  logic [3:0]       condCode,
  input  logic [3:0]       flags,
  input  logic             is32,
  input  logic             zeroA,
  input  logic             zeroB,
  input  logic [DataW-1:0] opA,
  input  logic [DataW-1:0] opB,
  output logic             outValid,
  output logic [DataW-1:0] result
);
  cselCtrl_t ctrl;

  csel_ctrl u_ctrl (
    .inValid(inValid), .opSel(opSel), .condCode(condCode), .flags(flags),
    .is32(is32), .zeroA(zeroA), .zeroB(zeroB), .ctrl(ctrl)
  );

  csel_datapath #(.Width(DataW)) u_dp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .opA(opA), .opB(opB),
    .outValid(outValid), .result(result)
  );
endmodule

// File: rtl/csel_unit_checker.sv
module csel_unit_checker
  import csel_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             inValid,
  input logic [1:0]       opSel,
  input logic [3:0]       condCode,
  input logic             is32,
  input logic             zeroA,
  input logic             zeroB,
  input logic [DataW-1:0] opA,
  input logic [DataW-1:0] opB,
  input logic             outValid,
  input logic [DataW-1:0] result
);
  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    outValid == $past(inValid)); // R9
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> $stable(result)); // R9
  AST_UPPER_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && is32) |=> result[DataW-1:HalfW] == '0); // R8
  AST_ALWAYS_TAKE_A: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !is32 && condCode[3:1] == 3'b111)
      |=> result == $past(zeroA ? '0 : opA)); // R1
  AST_PASS_ZEROS: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && zeroA && zeroB && opSel == 2'd0) |=> result == '0); // R7
  always_comb begin
    if (!rstN) begin
      AST_RESET_CLEAR: assert (outValid == 1'b0 && result == '0); // R10
    end
  end
endmodule

bind csel_unit csel_unit_checker u_chk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .opSel(opSel),
  .condCode(condCode), .is32(is32), .zeroA(zeroA), .zeroB(zeroB),
  .opA(opA), .opB(opB), .outValid(outValid), .result(result)
);

// File: tb/csel_unit_bench.sv
module csel_unit_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [1:0]  opSel = '0;
  logic [3:0]  condCode = '0;
  logic [3:0]  flags = '0;
  logic        is32 = 1'b0;
  logic        zeroA = 1'b0;
  logic        zeroB = 1'b0;
  logic [63:0] opA = '0;
  logic [63:0] opB = '0;
  logic        outValid;
  logic [63:0] result;

  int checks = 0;
  int fails = 0;
  logic        expValid = 1'b0;
  logic [63:0] expResult = '0;
  logic [63:0] lastA, lastB;
  bit          done = 0;

  always #10 clk = ~clk;

  csel_unit u_csel_unit (
    .clk(clk), .rstN(rstN), .inValid(inValid), .opSel(opSel),
    .condCode(condCode), .flags(flags), .is32(is32), .zeroA(zeroA),
    .zeroB(zeroB), .opA(opA), .opB(opB), .outValid(outValid), .result(result)
  );

  function automatic bit condModel(input logic [3:0] cc, input logic [3:0] f);
    bit n, z, c, v, base;
    n = f[3]; z = f[2]; c = f[1]; v = f[0];
    if (cc >= 4'd14) return 1'b1;
    case (cc >> 1)
      0: base = z;
      1: base = c;
      2: base = n;
      3: base = v;
      4: base = c && !z;
      5: base = (n == v);
      default: base = !z && (n == v);
    endcase
    return (cc % 2 == 1) ? !base : base;
  endfunction

  function automatic logic [63:0] refModel(input logic [1:0] op, input logic [3:0] cc,
      input logic [3:0] f, input bit w32, input bit za, input bit zb,
      input logic [63:0] a, input logic [63:0] b);
    logic [63:0] av, bv, r;
    av = za ? 64'd0 : a;
    bv = zb ? 64'd0 : b;
    if (condModel(cc, f)) r = av;
    else if (op == 0) r = bv;
    else if (op == 1) r = ~bv;
    else if (op == 2) r = 64'd0 - bv;
    else r = bv + 64'd1;
    if (w32) r = r & 64'h0000_0000_FFFF_FFFF;
    return r;
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Drive one operation, then compare result at the next negedge.
  task automatic issue(input string req, input logic [1:0] op, input logic [3:0] cc,
      input logic [3:0] f, input bit w32, input bit za, input bit zb,
      input logic [63:0] a, input logic [63:0] b);
    inValid = 1'b1; opSel = op; condCode = cc; flags = f; is32 = w32;
    zeroA = za; zeroB = zb; opA = a; opB = b;
    expResult = refModel(op, cc, f, w32, za, zb, a, b);
    @(negedge clk);
    check(req, result, expResult);
    check("R9 valid", {63'd0, outValid}, 64'd1);
    inValid = 1'b0;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R10 reset result", result, 64'd0);
    check("R10 reset valid", {63'd0, outValid}, 64'd0);
    rstN = 1'b1;
    @(negedge clk);

    // R6: sweep condition codes and flags, using pass with A=1, B=0
    for (int cc = 0; cc < 16; cc++)
      for (int f = 0; f < 16; f++)
        issue("R6 cond", 2'd0, 4'(cc), 4'(f), 0, 0, 0, 64'd1, 64'd0);

    // R1: condition true (AL) for all ops
    for (int op = 0; op < 4; op++)
      issue("R1 take A", 2'(op), 4'd14, 4'd0, 0, 0, 0, 64'hDEAD_BEEF_0123_4567, 64'h5);

    // False condition: EQ with Z=0
    begin
      logic [63:0] pats[5] = '{64'd0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_FFFF_FFFF,
                                64'h8000_0000_0000_0000, 64'h1234_5678_9ABC_DEF0};
      foreach (pats[i]) begin
        issue("R2 pass", 2'd0, 4'd0, 4'd0, 0, 0, 0, 64'h1, pats[i]);
        issue("R3 invert", 2'd1, 4'd0, 4'd0, 0, 0, 0, 64'h1, pats[i]);
        issue("R4 negate", 2'd2, 4'd0, 4'd0, 0, 0, 0, 64'h1, pats[i]);
        issue("R5 increment", 2'd3, 4'd0, 4'd0, 0, 0, 0, 64'h1, pats[i]);
        for (int op = 0; op < 4; op++)
          issue("R8 32-bit", 2'(op), 4'd0, 4'd0, 1, 0, 0, 64'h1, pats[i]);
        issue("R8 32-bit take A", 2'd0, 4'd0, 4'd4, 1, 0, 0, pats[i], 64'd0);
      end
    end
    check("R5 wrap", refModel(2'd3, 4'd0, 4'd0, 0, 0, 0, 0, '1), 64'd0);

    // R7 and derived forms: set-on-condition (inc, NE code with Z=1 -> EQ true -> 1)
    issue("R7 cset true", 2'd3, 4'd1, 4'b0100, 0, 1, 1, 64'h77, 64'h99);
    check("R7 cset value", result, 64'd1);
    issue("R7 cset false", 2'd3, 4'd1, 4'b0000, 0, 1, 1, 64'h77, 64'h99);
    check("R7 cset zero", result, 64'd0);
    issue("R7 csetm true", 2'd1, 4'd1, 4'b0100, 0, 1, 1, 64'h77, 64'h99);
    check("R7 csetm mask", result, 64'hFFFF_FFFF_FFFF_FFFF);
    issue("R7 zeroA only", 2'd0, 4'd14, 4'd0, 0, 1, 0, 64'h77, 64'h99);
    issue("R3 cinv", 2'd1, 4'd0, 4'd0, 0, 0, 0, 64'h0F0F, 64'h0F0F);
    issue("R4 cneg", 2'd2, 4'd1, 4'b0100, 0, 0, 0, 64'd5, 64'd5);

    // R9: idle cycles with changing inputs hold result
    issue("R9 load", 2'd0, 4'd14, 4'd0, 0, 0, 0, 64'hCAFE, 64'd0);
    lastA = result;
    opA = 64'h1111; condCode = 4'd14;
    @(negedge clk);
    check("R9 idle valid", {63'd0, outValid}, 64'd0);
    check("R9 hold", result, lastA);
    opA = 64'h2222;
    @(negedge clk);
    check("R9 hold2", result, lastA);
    lastB = lastA;

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule